// File: doc/BRIEF.md
# Write-Locked Configuration Register Bank

This block is a byte-wide bank of configuration registers on a simple synchronous host bus. The bus has an address, write data, a write strobe, a read strobe and registered read data. The bank holds three fixed identification bytes, a scratch byte that is always writable, and a two-byte unlock key. While the key holds its one accepted value, the host may write the upper control region. At any other time, writes to that region are silently dropped.

The control region holds three things:
- A pulse location that issues a software global reset. This reset clears every register, including the key, exactly as the hardware reset pin does.
- A device control byte that drives the loopback enable, the protection-switch source select and the drive enable for the receive overhead clock-enable and frame-pulse outputs.
- Two bytes that supply the per-channel switch-mux selects and output enables when software owns the switches.

When the source select points at hardware, the per-channel controls follow external pins instead. The transceivers, muxes and pads are outside this block; only their control signals leave it.

Top module: `cfg_lock_bank`

## Requirements
- R1: Addresses 0x00, 0x01 and 0x02 always read 0x05, 0x80 and 0x80; writes to them change nothing.
- R2: Address 0x03 is a scratch byte that resets to 0x00 and can be written and read back whether the bank is locked or unlocked.
- R3: Addresses 0x04 (key high) and 0x05 (key low) reset to 0x00, are writable in any lock state and read back what was written.
- R4: A write to any address from 0x06 to 0x7F takes effect only while key high is 0x05 and key low is 0x80; writing any other value to either key byte locks the bank again, and locked writes are discarded.
- R5: An accepted write with bit 0 set to address 0x06 raises an internal reset one cycle later. At the clock edge after that, every register returns to its reset value, including the key (so the bank is locked), the scratch byte and the read data. Any bus access during the reset cycle is ignored.
- R6: Address 0x08 bit 0 drives `loopbackEn`, bit 3 drives `protHwSel` and bit 4 drives `ohDriveEn` (0 = outputs high impedance, 1 = driven). All reset to 0, and the other bits read back as 0.
- R7: `chanMuxSel` equals the byte at address 0x09 while `protHwSel` is 0, and follows the `hwProtSw` pins while it is 1.
- R8: `chanOutEn` equals the byte at address 0x0A while `protHwSel` is 0, and follows the `hwOutEn` pins while it is 1.
- R9: Read data is registered and appears in the cycle after the read strobe. It holds its value when no read is made, and any unimplemented address (0x06, 0x07, 0x0B to 0x7F) reads 0x00.
- R10: A low `rstN` clears every register at once. Release is synchronized, so the first accepted bus access is in the third clock cycle after `rstN` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| hostAddr | input | 7 | Register address |
| hostWrData | input | 8 | Write data |
| hostWr | input | 1 | Write strobe |
| hostRd | input | 1 | Read strobe |
| hostRdData | output | 8 | Registered read data |
| hwProtSw | input | 8 | Hardware per-channel mux selects |
| hwOutEn | input | 8 | Hardware per-channel output enables |
| loopbackEn | output | 1 | Serial loopback enable |
| protHwSel | output | 1 | 1 = switch controls come from pins |
| ohDriveEn | output | 1 | Overhead clock-enable/frame outputs driven (1) or high impedance (0) |
| chanMuxSel | output | 8 | Per-channel switch-mux select |
| chanOutEn | output | 8 | Per-channel output enable |

## Verification
The bench covers these corner cases, and what a faulty design would show for each:
- **Control writes while locked.** A faulty design changes the control outputs.
- **Re-locking with a near-miss key byte (0x81).** A design that compares too few bits stays unlocked and accepts the write.
- **Writes to the identification bytes.** A faulty design alters the constants.
- **The software reset pulse.** The bench checks that the key, the scratch byte and the read data all clear one cycle after the acknowledged write. A design that forgot the key would stay unlocked, and one that fired at once would drop the acknowledging write. The bench also writes 0x00 to the pulse address, which must not reset anything.
- **Source select toggled while the hardware pins change.** A wrong select polarity drives software values where the pin values are expected.
- **Unimplemented reads and mid-run hardware reset.** A design that decodes addresses too loosely returns stale data on unimplemented reads. A faulty reset path leaves state behind after `rstN` drops mid-run.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

  localparam int unsigned ADR_REV    = 'h00;
  localparam int unsigned ADR_ID_LO  = 'h01;
  localparam int unsigned ADR_ID_HI  = 'h02;
  localparam int unsigned ADR_SCR    = 'h03;
  localparam int unsigned ADR_KEY_HI = 'h04;
  localparam int unsigned ADR_KEY_LO = 'h05;
  localparam int unsigned ADR_PULSE  = 'h06;
  localparam int unsigned ADR_DEVCTL = 'h08;
  localparam int unsigned ADR_MUXSEL = 'h09;
  localparam int unsigned ADR_OUTEN  = 'h0A;

  localparam int unsigned KEY_HI_VAL = 'h05;
  localparam int unsigned KEY_LO_VAL = 'h80;

  localparam int unsigned LOOP_BIT = 0;
  localparam int unsigned PROT_BIT = 3;
  localparam int unsigned OHZ_BIT  = 4;

  typedef struct packed {
    logic wrScratch;
    logic wrKeyHi;
    logic wrKeyLo;
    logic wrDevCtl;
    logic wrMuxSel;
    logic wrOutEn;
    logic rdStb;
    logic swReset;
  } bankStrobes_t;

endpackage

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl
  import cfg_lock_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstSyncN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              unlocked,
  output bankStrobes_t      strobes
);

  logic swRstQ;
  logic inLockRegion;
  logic wrOk;
  logic pulseReq;

  assign inLockRegion = hostAddr >= ADDR_W'(ADR_PULSE);
  assign wrOk         = hostWr && !swRstQ && (!inLockRegion || unlocked);
  assign pulseReq     = wrOk && (hostAddr == ADDR_W'(ADR_PULSE)) && hostWrData[0];

  always_comb begin
    strobes           = '0;
    strobes.wrScratch = wrOk && (hostAddr == ADDR_W'(ADR_SCR));
    strobes.wrKeyHi   = wrOk && (hostAddr == ADDR_W'(ADR_KEY_HI));
    strobes.wrKeyLo   = wrOk && (hostAddr == ADDR_W'(ADR_KEY_LO));
    strobes.wrDevCtl  = wrOk && (hostAddr == ADDR_W'(ADR_DEVCTL));
    strobes.wrMuxSel  = wrOk && (hostAddr == ADDR_W'(ADR_MUXSEL));
    strobes.wrOutEn   = wrOk && (hostAddr == ADDR_W'(ADR_OUTEN));
    strobes.rdStb     = hostRd && !swRstQ;
    strobes.swReset   = swRstQ;
  end

  // Registered pulse: acknowledging write completes, reset applies next edge.
  always_ff @(posedge clk or negedge rstSyncN) begin
    if (!rstSyncN)    swRstQ <= 1'b0;
    else if (swRstQ)  swRstQ <= 1'b0;
    else              swRstQ <= pulseReq;
  end

  // R5: software reset lasts exactly one cycle
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rstSyncN)
    swRstQ |=> !swRstQ);

  // R4: pulse location cannot fire while locked
  a_r4_pulse_blocked: assert property (@(posedge clk) disable iff (!rstSyncN)
    (hostWr && !unlocked && !swRstQ && hostAddr == ADDR_W'(ADR_PULSE)) |=> !swRstQ);

endmodule

// File: rtl/cfg_lock_dpath.sv
module cfg_lock_dpath
  import cfg_lock_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int NUM_CH = 8,
  parameter logic [DATA_W-1:0] REV_VAL   = 8'h05,
  parameter logic [DATA_W-1:0] ID_LO_VAL = 8'h80,
  parameter logic [DATA_W-1:0] ID_HI_VAL = 8'h80
) (
  input  logic              clk,
  input  logic              rstSyncN,
  input  bankStrobes_t      strobes,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [NUM_CH-1:0] hwProtSw,
  input  logic [NUM_CH-1:0] hwOutEn,
  output logic              unlocked,
  output logic [DATA_W-1:0] hostRdData,
  output logic              loopbackEn,
  output logic              protHwSel,
  output logic              ohDriveEn,
  output logic [NUM_CH-1:0] chanMuxSel,
  output logic [NUM_CH-1:0] chanOutEn
);

  logic [DATA_W-1:0] scratchQ, keyHiQ, keyLoQ, rdDataQ, rdNext, devByte;
  logic              loopQ, protQ, ohQ;
  logic [NUM_CH-1:0] muxSelQ, outEnQ;

  assign unlocked = (keyHiQ == DATA_W'(KEY_HI_VAL)) && (keyLoQ == DATA_W'(KEY_LO_VAL));

  always_ff @(posedge clk or negedge rstSyncN) begin
    if (!rstSyncN) begin
      scratchQ <= '0; keyHiQ <= '0; keyLoQ <= '0;
      loopQ <= 1'b0; protQ <= 1'b0; ohQ <= 1'b0;
      muxSelQ <= '0; outEnQ <= '0; rdDataQ <= '0;
    end else if (strobes.swReset) begin
      scratchQ <= '0; keyHiQ <= '0; keyLoQ <= '0;
      loopQ <= 1'b0; protQ <= 1'b0; ohQ <= 1'b0;
      muxSelQ <= '0; outEnQ <= '0; rdDataQ <= '0;
    end else begin
      if (strobes.wrScratch) scratchQ <= hostWrData;
      if (strobes.wrKeyHi)   keyHiQ   <= hostWrData;
      if (strobes.wrKeyLo)   keyLoQ   <= hostWrData;
      if (strobes.wrDevCtl) begin
        loopQ <= hostWrData[LOOP_BIT];
        protQ <= hostWrData[PROT_BIT];
        ohQ   <= hostWrData[OHZ_BIT];
      end
      if (strobes.wrMuxSel)  muxSelQ <= hostWrData[NUM_CH-1:0];
      if (strobes.wrOutEn)   outEnQ  <= hostWrData[NUM_CH-1:0];
      if (strobes.rdStb)     rdDataQ <= rdNext;
    end
  end

  always_comb begin
    devByte           = '0;
    devByte[LOOP_BIT] = loopQ;
    devByte[PROT_BIT] = protQ;
    devByte[OHZ_BIT]  = ohQ;
  end

  always_comb begin
    case (hostAddr)
      ADDR_W'(ADR_REV):    rdNext = REV_VAL;
      ADDR_W'(ADR_ID_LO):  rdNext = ID_LO_VAL;
      ADDR_W'(ADR_ID_HI):  rdNext = ID_HI_VAL;
      ADDR_W'(ADR_SCR):    rdNext = scratchQ;
      ADDR_W'(ADR_KEY_HI): rdNext = keyHiQ;
      ADDR_W'(ADR_KEY_LO): rdNext = keyLoQ;
      ADDR_W'(ADR_DEVCTL): rdNext = devByte;
      ADDR_W'(ADR_MUXSEL): rdNext = DATA_W'(muxSelQ);
      ADDR_W'(ADR_OUTEN):  rdNext = DATA_W'(outEnQ);
      default:             rdNext = '0;
    endcase
  end

  assign hostRdData = rdDataQ;
  assign loopbackEn = loopQ;
  assign protHwSel  = protQ;
  assign ohDriveEn  = ohQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    assign chanMuxSel[ch] = protQ ? hwProtSw[ch] : muxSelQ[ch];
    assign chanOutEn[ch]  = protQ ? hwOutEn[ch]  : outEnQ[ch];
  end

  // R4: control state frozen while locked
  a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rstSyncN)
    (!unlocked && !strobes.swReset) |=>
      ($stable(loopQ) && $stable(protQ) && $stable(ohQ) &&
       $stable(muxSelQ) && $stable(outEnQ)));

  // R5: software reset clears key and scratch
  a_r5_key_cleared: assert property (@(posedge clk) disable iff (!rstSyncN)
    strobes.swReset |=> (keyHiQ == '0 && keyLoQ == '0 && scratchQ == '0 && !unlocked));

  // R9: unimplemented addresses read zero
  a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (!rstSyncN)
    (strobes.rdStb && (hostAddr > ADDR_W'(ADR_OUTEN) || hostAddr == ADDR_W'(ADR_PULSE) ||
     hostAddr == ADDR_W'(ADR_PULSE + 1))) |=> (hostRdData == '0));

endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank
  import cfg_lock_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int NUM_CH = 8,
  parameter logic [DATA_W-1:0] REV_VAL   = 8'h05,
  parameter logic [DATA_W-1:0] ID_LO_VAL = 8'h80,
  parameter logic [DATA_W-1:0] ID_HI_VAL = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostWr,
  input  logic              hostRd,
  output logic [DATA_W-1:0] hostRdData,
  input  logic [NUM_CH-1:0] hwProtSw,
  input  logic [NUM_CH-1:0] hwOutEn,
  output logic              loopbackEn,
  output logic              protHwSel,
  output logic              ohDriveEn,
  output logic [NUM_CH-1:0] chanMuxSel,
  output logic [NUM_CH-1:0] chanOutEn
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rstSync;
  logic                   rstSyncN;
  logic                   unlocked;
  bankStrobes_t           strobes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstSync <= '0;
    else       rstSync <= {rstSync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rstSyncN = rstSync[SYNC_STAGES-1];

  cfg_lock_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstSyncN(rstSyncN), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostWr(hostWr), .hostRd(hostRd), .unlocked(unlocked), .strobes(strobes)
  );

  cfg_lock_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH),
    .REV_VAL(REV_VAL), .ID_LO_VAL(ID_LO_VAL), .ID_HI_VAL(ID_HI_VAL)
  ) dpath_i (
    .clk(clk), .rstSyncN(rstSyncN), .strobes(strobes), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hwProtSw(hwProtSw), .hwOutEn(hwOutEn),
    .unlocked(unlocked), .hostRdData(hostRdData), .loopbackEn(loopbackEn),
    .protHwSel(protHwSel), .ohDriveEn(ohDriveEn), .chanMuxSel(chanMuxSel),
    .chanOutEn(chanOutEn)
  );

endmodule

// File: tb/cfg_lock_bank_tb_top.sv
module cfg_lock_bank_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic       hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostRdData;
  logic [7:0] hwProtSw = '0, hwOutEn = '0;
  logic       loopbackEn, protHwSel, ohDriveEn;
  logic [7:0] chanMuxSel, chanOutEn;

  int checks = 0, fails = 0, cycles = 0;
  string curReq = "R10";
  bit done = 0;

  // reference model state
  int mScr, mKh, mKl, mDev, mMux, mOe, mRd, q1, q2;
  bit mSwPend;

  always #5 clk = ~clk;

  cfg_lock_bank dut_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostWr(hostWr), .hostRd(hostRd), .hostRdData(hostRdData),
    .hwProtSw(hwProtSw), .hwOutEn(hwOutEn), .loopbackEn(loopbackEn),
    .protHwSel(protHwSel), .ohDriveEn(ohDriveEn), .chanMuxSel(chanMuxSel),
    .chanOutEn(chanOutEn)
  );

  function automatic void mClear();
    mScr = 0; mKh = 0; mKl = 0; mDev = 0; mMux = 0; mOe = 0; mRd = 0; mSwPend = 0;
  endfunction

  function automatic int mRead(int a);
    case (a)
      0: return 'h05;  1: return 'h80;  2: return 'h80;
      3: return mScr;  4: return mKh;   5: return mKl;
      8: return mDev;  9: return mMux;  10: return mOe;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      q1 = 0; q2 = 0; mClear();
    end else begin
      bit held;
      held = (q2 == 0); q2 = q1; q1 = 1;
      if (held) mClear();
      else if (mSwPend) mClear();
      else begin
        bit unl;
        unl = (mKh == 'h05) && (mKl == 'h80);
        if (hostRd) mRd = mRead(int'(hostAddr));
        if (hostWr) begin
          case (int'(hostAddr))
            3: mScr = hostWrData;
            4: mKh = hostWrData;
            5: mKl = hostWrData;
            default: if (unl) begin
              if (hostAddr == 6 && hostWrData[0]) mSwPend = 1;
              if (hostAddr == 8)  mDev = hostWrData & 'h19;
              if (hostAddr == 9)  mMux = hostWrData;
              if (hostAddr == 10) mOe  = hostWrData;
            end
          endcase
        end
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // compare against model every cycle
  always @(negedge clk) begin
    if (!done) begin
      int eMux, eOe;
      eMux = (mDev & 8) ? int'(hwProtSw) : mMux;
      eOe  = (mDev & 8) ? int'(hwOutEn)  : mOe;
      check(curReq, "rdData", int'(hostRdData), mRd);
      check("R6", "loopbackEn", int'(loopbackEn), (mDev >> 0) & 1);
      check("R6", "protHwSel", int'(protHwSel), (mDev >> 3) & 1);
      check("R6", "ohDriveEn", int'(ohDriveEn), (mDev >> 4) & 1);
      check("R7", "chanMuxSel", int'(chanMuxSel), eMux);
      check("R8", "chanOutEn", int'(chanOutEn), eOe);
    end
  end

  task automatic wrReg(int a, int d);
    @(negedge clk); #1;
    hostAddr = 7'(a); hostWrData = 8'(d); hostWr = 1'b1;
    @(negedge clk); #1;
    hostWr = 1'b0;
  endtask

  task automatic rdExpect(int a, int exp, string req);
    @(negedge clk); #1;
    hostAddr = 7'(a); hostRd = 1'b1;
    @(negedge clk); #1;
    hostRd = 1'b0;
    check(req, $sformatf("read addr %0h", a), int'(hostRdData), exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    idle(3); #1; rstN = 1'b1;
    idle(4);
    // R10 / R1 / R3 reset values
    curReq = "R1";  rdExpect(0, 'h05, "R1"); rdExpect(1, 'h80, "R1"); rdExpect(2, 'h80, "R1");
    curReq = "R3";  rdExpect(4, 0, "R3"); rdExpect(5, 0, "R3");
    curReq = "R6";  rdExpect(8, 0, "R6");
    // R1: writes to IDs ignored
    curReq = "R1";  wrReg(0, 'h33); wrReg(2, 'h11); rdExpect(0, 'h05, "R1"); rdExpect(2, 'h80, "R1");
    // R2: scratch while locked
    curReq = "R2";  wrReg(3, 'hA7); rdExpect(3, 'hA7, "R2");
    // R4: locked control write dropped
    curReq = "R4";  wrReg(8, 'hFF); wrReg(9, 'hFF); rdExpect(8, 0, "R4"); rdExpect(9, 0, "R4");
    // R3: unlock
    curReq = "R3";  wrReg(4, 'h05); wrReg(5, 'h80); rdExpect(4, 'h05, "R3"); rdExpect(5, 'h80, "R3");
    // R6: control byte fields
    curReq = "R6";  wrReg(8, 'hFF); rdExpect(8, 'h19, "R6");
    check("R6", "loopbackEn direct", int'(loopbackEn), 1);
    wrReg(8, 'h10); rdExpect(8, 'h10, "R6");
    // R7 / R8 software source
    curReq = "R7";  wrReg(9, 'hA5); wrReg(10, 'h3C);
    check("R7", "sw mux", int'(chanMuxSel), 'hA5);
    check("R8", "sw oe", int'(chanOutEn), 'h3C);
    // hardware source with changing pins
    @(negedge clk); #1; hwProtSw = 8'h5A; hwOutEn = 8'hC3;
    curReq = "R8";  wrReg(8, 'h18);
    check("R7", "hw mux", int'(chanMuxSel), 'h5A);
    check("R8", "hw oe", int'(chanOutEn), 'hC3);
    @(negedge clk); #1; hwProtSw = 8'h0F; hwOutEn = 8'hF0;
    idle(2);
    wrReg(8, 'h00);
    check("R7", "back to sw mux", int'(chanMuxSel), 'hA5);
    // R4: near-miss key relocks
    curReq = "R4";  wrReg(5, 'h81); wrReg(9, 'h11); rdExpect(9, 'hA5, "R4");
    wrReg(5, 'h80); wrReg(4, 'h04); wrReg(10, 'h01); rdExpect(10, 'h3C, "R4");
    wrReg(4, 'h05);
    // R9: unimplemented addresses
    curReq = "R9";  wrReg('h40, 'hFF); rdExpect('h40, 0, "R9"); rdExpect('h7F, 0, "R9");
    rdExpect(7, 0, "R9");
    idle(3); check("R9", "rd hold", int'(hostRdData), 0);
    rdExpect(9, 'hA5, "R9"); idle(2); check("R9", "rd hold", int'(hostRdData), 'hA5);
    // R5: zero to pulse does nothing, one resets all
    curReq = "R5";  wrReg(3, 'h77); wrReg(8, 'h19); wrReg(6, 'h00); rdExpect(4, 'h05, "R5");
    wrReg(6, 'h01); idle(2);
    rdExpect(4, 0, "R5"); rdExpect(5, 0, "R5"); rdExpect(3, 0, "R5");
    check("R5", "loopback cleared", int'(loopbackEn), 0);
    wrReg(8, 'h01); rdExpect(8, 0, "R5");
    // R10: mid-run hardware reset
    curReq = "R10"; wrReg(3, 'h5C); wrReg(4, 'h05); wrReg(5, 'h80); wrReg(8, 'h19);
    @(negedge clk); #1; rstN = 1'b0; #2;
    check("R10", "async loopback", int'(loopbackEn), 0);
    check("R10", "async rdData", int'(hostRdData), 0);
    idle(2); #1; rstN = 1'b1;
    idle(4);
    rdExpect(3, 0, "R10"); rdExpect(4, 0, "R10");
    wrReg(3, 'h21); rdExpect(3, 'h21, "R10");
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule